// File: doc/BRIEF.md
# Prioritised Two-Channel Interrupt Controller

This block collects 32 interrupt lines and presents them to a processor as two request outputs: a normal channel and a fast channel. Each line has a configuration word that sets its priority, makes it edge-sensitive or level-sensitive, and routes it to one of the two channels. A 32-bit pending register records which lines have fired, and a 32-bit mask register (1 = masked) keeps lines from being arbitrated.

Each channel runs a two-state machine. In `CH_ARMED` the output is low, and the channel watches for any unmasked pending line routed to it. When it sees one (the transition *raise*), it latches the winning line number and enters `CH_RAISED`, driving its output high. It stays there until software writes an agreement command to the control register (the transition *agree*), which returns it to `CH_ARMED`. If another line is still eligible, the channel raises again on the next cycle. When software reads a channel's vector register, it gets the latched line number, and the read clears that line's pending bit if the line is edge-sensitive. A software-trigger register lets code fire a line as if its input had asserted.

Software reaches the block through a single-cycle word port: valid, write, byte address and data. Reads return data combinationally in the same cycle, and any side effect of the access takes place at the clock edge.

Top module: `irq_ctl32`

## Requirements
- R1: After reset, pending is 0, mask is all ones, every configuration word is 0, both vector registers read 0 and both outputs are low.
- R2: An edge-sensitive line becomes pending when its sampled input goes from 0 to 1. Its pending bit stays set after the input drops.
- R3: A level-sensitive line is pending while its input is high, and its pending bit clears in the cycle its input falls. A write of 0 to the pending register cannot clear it while the input is still high.
- R4: A write to offset 0x00 ANDs the pending register with the written data, so a 0 bit clears an edge line or a level line whose input is low. Writing 1s never sets a bit.
- R5: Offset 0x04 is the mask register (bit n = 1 masks line n). A masked line still records pending but cannot raise a channel. Unmasking a pending line raises its channel one cycle after the write.
- R6: An armed channel drives its output high two clock edges after an eligible input rises. Configuration bit 0 selects the channel: 0 is normal, 1 is fast. The output stays high until an agreement command, even after the line's pending bit has cleared.
- R7: Among eligible lines, the lowest priority value wins. On equal priority, the higher line number wins.
- R8: Reading 0x10 (normal) or 0x14 (fast) returns the channel's latched line number and clears that line's pending bit only if the line is edge-sensitive. Writes to these offsets are ignored.
- R9: Writing 0x18 with bit 0 set re-arms the normal channel, and with bit 1 set re-arms the fast channel. The output is low for the cycle after the write and rises again one cycle later if a line is still eligible. Offset 0x18 reads 0.
- R10: The configuration word for line n is at 0x1C + 4n. Bits [6:2] hold the priority, bit 1 is 1 for level-sensitive, and bit 0 is 1 for fast. It reads back in the same layout.
- R11: A write to 0x9C triggers only the lowest-numbered set bit of the data. That line then behaves as if its input had asserted, and an edge line does so only if its input is currently low. Offset 0x9C reads 0.
- R12: Any other offset, including misaligned ones, reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 32 | Interrupt line inputs, active high |
| bus_valid | input | 1 | Access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read |
| irq_norm | output | 1 | Normal channel request |
| irq_fast | output | 1 | Fast channel request |

## Verification
The hardest situation to reach is a channel re-arming while other lines are still pending. The winner then depends on the priority tie-break, and the previous winner's pending bit must already have been cleared by a vector read. The stimulus sets three lines on the normal channel in the same cycle, two of them at equal priority. It then alternates vector reads and agreement commands, expecting the winners in priority order first and then by descending line number. A second hard case is a level line whose input is still high: a clearing write and a vector read must both leave it pending, which is only visible by reading the pending register back after each of them.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

    // Channel state machine states
    typedef enum logic [0:0] {
        CH_ARMED  = 1'b0,
        CH_RAISED = 1'b1
    } chan_state_e;

    // Register offsets (byte addresses)
    localparam int OFS_PEND   = 'h00;
    localparam int OFS_MASK   = 'h04;
    localparam int OFS_VEC_N  = 'h10;
    localparam int OFS_VEC_F  = 'h14;
    localparam int OFS_CTRL   = 'h18;
    localparam int OFS_CFG0   = 'h1C;
    localparam int OFS_SWTRIG = 'h9C;

endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
    parameter int N_LINES = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] irq_in,
    input  logic [N_LINES-1:0] lvl,
    input  logic [N_LINES-1:0] sw_hit,
    input  logic               wr_pend,
    input  logic [N_LINES-1:0] wr_data,
    input  logic [N_LINES-1:0] ack_line,
    output logic [N_LINES-1:0] pend_q,
    output logic [N_LINES-1:0] raw_q
);

    logic [N_LINES-1:0] rise, fall, set_v, clr_v, keep_v, pend_d;

    always_comb begin
        rise   = irq_in & ~raw_q;
        fall   = ~irq_in & raw_q;
        // edge lines: new rising input or software trigger with input low
        // level lines: input high or software trigger
        set_v  = (~lvl & (rise | (sw_hit & ~raw_q))) | (lvl & (irq_in | sw_hit));
        // clearing write cannot touch level lines whose input is still high
        keep_v = wr_pend ? (wr_data | (raw_q & lvl)) : '1;
        clr_v  = (lvl & fall) | (~lvl & ack_line);
        pend_d = ((pend_q & keep_v) & ~clr_v) | set_v;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            raw_q  <= '0;
        end else begin
            pend_q <= pend_d;
            raw_q  <= irq_in;
        end
    end

    // A level line sampled high must be pending one edge later
    assert_level_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((~$past(irq_in & lvl) | pend_q) == '1));

    // An edge line only becomes pending through a rising input or a trigger
    assert_edge_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |->
        ((pend_q & ~$past(pend_q) & ~$past(lvl) & ~$past(rise | sw_hit)) == '0));

    // Software trigger selects at most one line per write
    assert_trigger_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sw_hit));

endmodule

// File: rtl/irq_prio_sorter.sv
module irq_prio_sorter #(
    parameter int N_LINES = 32,
    parameter int PRIO_W  = 5,
    localparam int IDXW   = $clog2(N_LINES)
) (
    input  logic [N_LINES-1:0]             pend,
    input  logic [N_LINES-1:0]             mask,
    input  logic [N_LINES-1:0]             route,
    input  logic [N_LINES-1:0][PRIO_W-1:0] prio,
    output logic [1:0]                     win_any,
    output logic [1:0][IDXW-1:0]           win_idx
);

    for (genvar ch = 0; ch < 2; ch++) begin : g_chan
        logic [N_LINES-1:0] elig;
        logic [PRIO_W:0]    best;
        logic [IDXW-1:0]    idx;
        logic               any;

        // channel 1 takes lines routed fast, channel 0 the rest
        assign elig = pend & ~mask & ((ch == 1) ? route : ~route);

        // scan upward; "<=" lets a later line win a tie
        always_comb begin
            best = {(PRIO_W+1){1'b1}};
            idx  = '0;
            any  = 1'b0;
            for (int i = 0; i < N_LINES; i++) begin
                if (elig[i] && ({1'b0, prio[i]} <= best)) begin
                    best = {1'b0, prio[i]};
                    idx  = IDXW'(i);
                    any  = 1'b1;
                end
            end
        end

        assign win_any[ch] = any;
        assign win_idx[ch] = idx;
    end

endmodule

// File: rtl/irq_chan_fsm.sv
module irq_chan_fsm
    import irq_ctl_pkg::*;
#(
    parameter int IDXW = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            win_any,
    input  logic [IDXW-1:0] win_idx,
    input  logic            agree,
    output logic            irq_o,
    output logic [IDXW-1:0] code_o
);

    chan_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_ARMED;
        else        state_q <= state_d;
    end

    // transitions: raise (armed -> raised), agree (raised -> armed)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_ARMED:  if (win_any) state_d = CH_RAISED;
            CH_RAISED: if (agree)   state_d = CH_ARMED;
            default:   state_d = CH_ARMED;
        endcase
    end

    // outputs: latched winner code and request line
    always_ff @(posedge clk) begin
        if (!rst_n)                                code_o <= '0;
        else if (state_q == CH_ARMED && win_any)   code_o <= win_idx;
    end

    assign irq_o = (state_q == CH_RAISED);

    assert_rise_needs_winner_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(win_any));

    assert_fall_needs_agree_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o) |-> $past(agree));

    assert_code_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && $past(irq_o)) |-> $stable(code_o));

endmodule

// File: rtl/irq_ctl32.sv
module irq_ctl32
    import irq_ctl_pkg::*;
#(
    parameter int N_LINES = 32,
    parameter int PRIO_W  = 5,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    localparam int IDXW   = $clog2(N_LINES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] irq_in,
    input  logic               bus_valid,
    input  logic               bus_write,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               irq_norm,
    output logic               irq_fast
);

    // configuration and mask state
    logic [N_LINES-1:0]             mask_q, lvl_q, route_q;
    logic [N_LINES-1:0][PRIO_W-1:0] prio_q;

    logic [N_LINES-1:0]   pend_q, raw_q;
    logic [1:0]           win_any;
    logic [1:0][IDXW-1:0] win_idx;
    logic [1:0][IDXW-1:0] code;
    logic [1:0]           irq_vec;
    logic [1:0]           agree;

    // decode
    logic              wr, rd;
    logic              hit_pend, hit_mask, hit_vn, hit_vf, hit_ctrl, hit_cfg, hit_sw;
    logic [ADDR_W-1:0] cfg_off;
    logic [IDXW-1:0]   cfg_idx;
    logic [N_LINES-1:0] wd_lines, sw_hit, ack_line;

    assign wr       = bus_valid & bus_write;
    assign rd       = bus_valid & ~bus_write;
    assign hit_pend = (bus_addr == ADDR_W'(OFS_PEND));
    assign hit_mask = (bus_addr == ADDR_W'(OFS_MASK));
    assign hit_vn   = (bus_addr == ADDR_W'(OFS_VEC_N));
    assign hit_vf   = (bus_addr == ADDR_W'(OFS_VEC_F));
    assign hit_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
    assign hit_sw   = (bus_addr == ADDR_W'(OFS_SWTRIG));
    assign cfg_off  = bus_addr - ADDR_W'(OFS_CFG0);
    assign hit_cfg  = (bus_addr >= ADDR_W'(OFS_CFG0)) &&
                      (int'(cfg_off) < 4 * N_LINES) && (cfg_off[1:0] == 2'b00);
    assign cfg_idx  = cfg_off[IDXW+1:2];
    assign wd_lines = bus_wdata[N_LINES-1:0];

    // software trigger: isolate the lowest set bit
    assign sw_hit = (wr && hit_sw) ? (wd_lines & (~wd_lines + N_LINES'(1))) : '0;

    // vector reads acknowledge the latched line of that channel
    always_comb begin
        ack_line = '0;
        if (rd && hit_vn) ack_line = ack_line | (N_LINES'(1) << code[0]);
        if (rd && hit_vf) ack_line = ack_line | (N_LINES'(1) << code[1]);
    end

    assign agree[0] = wr && hit_ctrl && bus_wdata[0];
    assign agree[1] = wr && hit_ctrl && bus_wdata[1];

    // mask and configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q  <= '1;
            lvl_q   <= '0;
            route_q <= '0;
            prio_q  <= '0;
        end else begin
            if (wr && hit_mask) mask_q <= wd_lines;
            for (int i = 0; i < N_LINES; i++) begin
                if (wr && hit_cfg && (cfg_idx == IDXW'(i))) begin
                    prio_q[i]  <= bus_wdata[PRIO_W+1:2];
                    lvl_q[i]   <= bus_wdata[1];
                    route_q[i] <= bus_wdata[0];
                end
            end
        end
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (rd) begin
            if (hit_pend)      bus_rdata = DATA_W'(pend_q);
            else if (hit_mask) bus_rdata = DATA_W'(mask_q);
            else if (hit_vn)   bus_rdata = DATA_W'(code[0]);
            else if (hit_vf)   bus_rdata = DATA_W'(code[1]);
            else if (hit_cfg)  bus_rdata = DATA_W'({prio_q[cfg_idx], lvl_q[cfg_idx], route_q[cfg_idx]});
        end
    end

    irq_pend_bank #(
        .N_LINES (N_LINES)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_in   (irq_in),
        .lvl      (lvl_q),
        .sw_hit   (sw_hit),
        .wr_pend  (wr && hit_pend),
        .wr_data  (wd_lines),
        .ack_line (ack_line),
        .pend_q   (pend_q),
        .raw_q    (raw_q)
    );

    irq_prio_sorter #(
        .N_LINES (N_LINES),
        .PRIO_W  (PRIO_W)
    ) u_sort (
        .pend    (pend_q),
        .mask    (mask_q),
        .route   (route_q),
        .prio    (prio_q),
        .win_any (win_any),
        .win_idx (win_idx)
    );

    for (genvar ch = 0; ch < 2; ch++) begin : g_fsm
        irq_chan_fsm #(
            .IDXW (IDXW)
        ) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .win_any (win_any[ch]),
            .win_idx (win_idx[ch]),
            .agree   (agree[ch]),
            .irq_o   (irq_vec[ch]),
            .code_o  (code[ch])
        );
    end

    assign irq_norm = irq_vec[0];
    assign irq_fast = irq_vec[1];

    // A raise needs an unmasked pending line on that channel one edge earlier
    assert_masked_no_raise_norm_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_norm) |-> $past(|(pend_q & ~mask_q & ~route_q)));

    assert_masked_no_raise_fast_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_fast) |-> $past(|(pend_q & ~mask_q & route_q)));

endmodule

// File: tb/irq_ctl32_tb.sv
module irq_ctl32_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 61;

    localparam logic [2:0] OP_WR = 3'd0, OP_RD = 3'd1, OP_IN = 3'd2, OP_IRQ = 3'd3, OP_IDLE = 3'd4;

    // entry: {req[3:0], op[2:0], addr[7:0], data[31:0], exp[31:0]}
    localparam logic [78:0] TBL [0:NV-1] = '{
        {4'd10, OP_WR,  8'h28, 32'h10,       32'h0},   // R10 line3 edge prio4 normal
        {4'd10, OP_RD,  8'h28, 32'h0,        32'h10},  // R10
        {4'd10, OP_WR,  8'h30, 32'h0B,       32'h0},   // R10 line5 level fast prio2
        {4'd10, OP_RD,  8'h30, 32'h0,        32'h0B},  // R10
        {4'd5,  OP_IN,  8'h00, 32'h8,        32'h0},   // R5 line3 up while masked
        {4'd5,  OP_IRQ, 8'h00, 32'h0,        32'h0},   // R5 no raise
        {4'd2,  OP_RD,  8'h00, 32'h0,        32'h8},   // R2 pending recorded
        {4'd5,  OP_WR,  8'h04, 32'hFFFFFFF7, 32'h0},   // R5 unmask line3
        {4'd5,  OP_IDLE,8'h00, 32'h0,        32'h0},
        {4'd6,  OP_IRQ, 8'h00, 32'h0,        32'h1},   // R6 normal raised
        {4'd2,  OP_IN,  8'h00, 32'h0,        32'h0},   // R2 input drops
        {4'd2,  OP_RD,  8'h00, 32'h0,        32'h8},   // R2 pending survives
        {4'd8,  OP_RD,  8'h10, 32'h0,        32'h3},   // R8 vector = 3
        {4'd8,  OP_RD,  8'h00, 32'h0,        32'h0},   // R8 edge acked
        {4'd6,  OP_IRQ, 8'h00, 32'h0,        32'h1},   // R6 held until agreement
        {4'd9,  OP_RD,  8'h18, 32'h0,        32'h0},   // R9 control reads 0
        {4'd9,  OP_WR,  8'h18, 32'h1,        32'h0},   // R9 agree normal
        {4'd9,  OP_IRQ, 8'h00, 32'h0,        32'h0},   // R9
        {4'd5,  OP_WR,  8'h04, 32'hFFFFFFD7, 32'h0},   // R5 unmask 3,5
        {4'd3,  OP_IN,  8'h00, 32'h20,       32'h0},   // R3 line5 up
        {4'd6,  OP_IRQ, 8'h00, 32'h0,        32'h2},   // R6 fast raised
        {4'd3,  OP_WR,  8'h00, 32'h0,        32'h0},   // R3 clear attempt
        {4'd3,  OP_RD,  8'h00, 32'h0,        32'h20},  // R3 still pending
        {4'd8,  OP_RD,  8'h14, 32'h0,        32'h5},   // R8 fast vector
        {4'd8,  OP_RD,  8'h00, 32'h0,        32'h20},  // R8 level not acked
        {4'd8,  OP_WR,  8'h14, 32'h1F,       32'h0},   // R8 write ignored
        {4'd8,  OP_RD,  8'h14, 32'h0,        32'h5},   // R8
        {4'd3,  OP_IN,  8'h00, 32'h0,        32'h0},   // R3 input falls
        {4'd3,  OP_RD,  8'h00, 32'h0,        32'h0},   // R3 cleared
        {4'd9,  OP_WR,  8'h18, 32'h2,        32'h0},   // R9 agree fast
        {4'd9,  OP_IRQ, 8'h00, 32'h0,        32'h0},   // R9
        {4'd7,  OP_WR,  8'h20, 32'h08,       32'h0},   // R7 line1 prio2
        {4'd7,  OP_WR,  8'h38, 32'h10,       32'h0},   // R7 line7 prio4
        {4'd5,  OP_WR,  8'h04, 32'hFFFFFF55, 32'h0},   // R5 unmask 1,3,5,7
        {4'd7,  OP_IN,  8'h00, 32'h8A,       32'h0},   // R7 lines 1,3,7 up
        {4'd7,  OP_RD,  8'h10, 32'h0,        32'h1},   // R7 lowest value wins
        {4'd9,  OP_WR,  8'h18, 32'h1,        32'h0},   // R9 rearm
        {4'd7,  OP_RD,  8'h10, 32'h0,        32'h7},   // R7 tie to higher index
        {4'd9,  OP_WR,  8'h18, 32'h1,        32'h0},   // R9
        {4'd7,  OP_RD,  8'h10, 32'h0,        32'h3},   // R7
        {4'd9,  OP_WR,  8'h18, 32'h1,        32'h0},   // R9
        {4'd9,  OP_IRQ, 8'h00, 32'h0,        32'h0},   // R9 nothing left
        {4'd8,  OP_RD,  8'h00, 32'h0,        32'h0},   // R8 all acked
        {4'd2,  OP_IN,  8'h00, 32'h0,        32'h0},
        {4'd11, OP_WR,  8'h04, 32'hFFFFFFFF, 32'h0},
        {4'd11, OP_WR,  8'h9C, 32'h30,       32'h0},   // R11 bits 4,5
        {4'd11, OP_RD,  8'h00, 32'h0,        32'h10},  // R11 only line4
        {4'd11, OP_RD,  8'h9C, 32'h0,        32'h0},   // R11 reads 0
        {4'd4,  OP_WR,  8'h00, 32'hFFFFFFEF, 32'h0},   // R4 clear line4
        {4'd4,  OP_RD,  8'h00, 32'h0,        32'h0},   // R4
        {4'd11, OP_WR,  8'h9C, 32'h20,       32'h0},   // R11 level line5
        {4'd11, OP_RD,  8'h00, 32'h0,        32'h20},  // R11
        {4'd4,  OP_WR,  8'h00, 32'h0,        32'h0},   // R4 level, input low
        {4'd4,  OP_RD,  8'h00, 32'h0,        32'h0},   // R4
        {4'd4,  OP_WR,  8'h00, 32'hFFFFFFFF, 32'h0},   // R4 ones never set
        {4'd4,  OP_RD,  8'h00, 32'h0,        32'h0},   // R4
        {4'd12, OP_WR,  8'h08, 32'hFFFFFFFF, 32'h0},   // R12
        {4'd12, OP_RD,  8'h08, 32'h0,        32'h0},   // R12
        {4'd12, OP_RD,  8'hA0, 32'h0,        32'h0},   // R12
        {4'd12, OP_WR,  8'h05, 32'h0,        32'h0},   // R12 misaligned mask write
        {4'd12, OP_RD,  8'h04, 32'h0,        32'hFFFFFFFF}  // R12 mask unchanged
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_in = '0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_norm, irq_fast;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_ctl32 u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_in    (irq_in),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_norm  (irq_norm),
        .irq_fast  (irq_fast)
    );

    task automatic check(input int req, input logic [31:0] got, input logic [31:0] exp, input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL R%0d %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic set_in(input logic [31:0] v);
        @(negedge clk);
        irq_in = v;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; irq_in = '0; bus_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] rv;
        do_reset();

        // table walk
        for (int k = 0; k < NV; k++) begin
            logic [78:0] e;
            int          rq;
            e  = TBL[k];
            rq = int'(e[78:75]);
            case (e[74:72])
                OP_WR:   bus_wr(e[71:64], e[63:32]);
                OP_RD:   begin bus_rd(e[71:64], rv); check(rq, rv, e[31:0], $sformatf("read %h row %0d", e[71:64], k)); end
                OP_IN:   set_in(e[63:32]);
                OP_IRQ:  begin #1 check(rq, {30'b0, irq_fast, irq_norm}, e[31:0], $sformatf("outputs row %0d", k)); end
                default: @(negedge clk);
            endcase
        end

        // R1: reset state
        do_reset();
        #1 check(1, {30'b0, irq_fast, irq_norm}, 32'h0, "outputs after reset");
        bus_rd(8'h00, rv); check(1, rv, 32'h0, "pending after reset");
        bus_rd(8'h04, rv); check(1, rv, 32'hFFFFFFFF, "mask after reset");
        bus_rd(8'h28, rv); check(1, rv, 32'h0, "config line3 after reset");
        bus_rd(8'h30, rv); check(1, rv, 32'h0, "config line5 after reset");
        bus_rd(8'h14, rv); check(1, rv, 32'h0, "fast vector after reset");

        // R6: exact raise latency on line 0 (edge, normal, prio 0)
        bus_wr(8'h04, 32'h0);
        @(negedge clk);
        irq_in = 32'h1;
        @(negedge clk);
        #1 check(6, {31'b0, irq_norm}, 32'h0, "one edge after input");
        @(negedge clk);
        #1 check(6, {31'b0, irq_norm}, 32'h1, "two edges after input");

        // R9: output drops for one cycle and rises again while line 0 pending
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 8'h18; bus_wdata = 32'h1;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
        #1 check(9, {31'b0, irq_norm}, 32'h0, "low after agreement");
        @(negedge clk);
        #1 check(9, {31'b0, irq_norm}, 32'h1, "re-raised with line pending");
        bus_rd(8'h10, rv); check(8, rv, 32'h0, "vector after re-raise");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule